// File: doc/BRIEF.md
# Arithmetic-Right Shifter Operand Unit

This unit produces the second operand of a data-processing operation, together with the carry that the shift pushes out, for the arithmetic-shift-right case. It takes the value to be shifted, a second register value, the instruction word, a mode select and the current carry flag. In immediate mode the shift distance is a five-bit field of the instruction word. In register mode the distance is the low byte of the second register value.

The instruction encoding has corner cases that a plain shifter would get wrong. A zero immediate stands for a shift by the full word width, so the result is filled with the sign bit. A register distance of zero leaves the value untouched and passes the incoming carry flag through. Register distances from the word width up to 255 saturate to sign fill. Each result is captured one cycle after an input valid strobe and is flagged by a single-cycle output valid. The result is held until the next strobe.

Top module: `asr_operand_unit`

## Requirements
- R1: With `mode_reg` = 0 the shift distance is `instr[11:7]`. No other instruction bit and no bit of `rs_val` affects the result.
- R2: In immediate mode with distance 0, `operand` is 32 copies of `rm_val[31]` and `carry_out` equals `rm_val[31]`.
- R3: In immediate mode with distance d in 1..31, `operand` is `rm_val` shifted right arithmetically by d and `carry_out` is `rm_val[d-1]`.
- R4: With `mode_reg` = 1 only `rs_val[7:0]` sets the distance. Bits `rs_val[31:8]` have no effect.
- R5: In register mode with distance 0, `operand` equals `rm_val` and `carry_out` equals `c_in`.
- R6: In register mode with distance d in 1..31, `operand` is `rm_val` shifted right arithmetically by d and `carry_out` is `rm_val[d-1]`.
- R7: In register mode with distance 32..255, `operand` is 32 copies of `rm_val[31]` and `carry_out` equals `rm_val[31]`.
- R8: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` is high. `operand` and `carry_out` change only in the cycle after a cycle with `in_valid` high, and hold their values otherwise.
- R9: `rst_n` is a synchronous, active-low reset. A clock edge that samples `rst_n` low clears `operand`, `carry_out` and `out_valid` to 0, whatever `in_valid` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Strobe: capture a new result at this edge |
| mode_reg | input | 1 | 0 = immediate distance, 1 = register distance |
| c_in | input | 1 | Current carry flag |
| rm_val | input | 32 | Value to be shifted |
| rs_val | input | 32 | Register holding the distance (low byte used) |
| instr | input | 32 | Instruction word (bits 11:7 hold the immediate distance) |
| out_valid | output | 1 | High for one cycle when a new result is present |
| operand | output | 32 | Shifted operand |
| carry_out | output | 1 | Carry shifted out |

## Verification
The hardest outcomes to reach from the ports are the edges between distance classes. These are a register distance of exactly 0, 31, 32 and 255, and the zero immediate that means a full-width shift. They matter most when the upper bits of `rs_val` are non-zero and would push a naive comparison into the wrong class. The stimulus sweeps every one of the 256 register distances and every one of the 32 immediate distances, each with a negative and a positive shifted value and with both carry-flag settings. It then repeats selected distances with random junk in `rs_val[31:8]` and in the unused instruction bits, so that any leak of those bits into the result shows up.

// File: rtl/asr_opu_pkg.sv
// Package: shared types for the arithmetic-right shifter operand unit.
// Assumes: the consumers size their data paths through their own parameters.
package asr_opu_pkg;

    // Class of shift selected by the decoder.
    typedef enum logic [1:0] {
        SH_PASS  = 2'd0,   // no shift, carry taken from flag
        SH_ARITH = 2'd1,   // 1 .. width-1 arithmetic shift
        SH_FILL  = 2'd2    // full-width or larger: sign fill
    } sh_kind_e;

endpackage

// File: rtl/asr_amount_decode.sv
// Module: asr_amount_decode
// Picks the shift distance from either the immediate field or the low byte
// of the register value, and sorts it into pass, arithmetic or fill class.
// Assumes: IMM_W equals log2(DATA_W) and REG_W is wider than IMM_W.
module asr_amount_decode
    import asr_opu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int IMM_LSB = 7,
    parameter int IMM_W   = 5,
    parameter int REG_W   = 8
) (
    input  logic                      mode_reg,
    input  logic [DATA_W-1:0]         instr,
    input  logic [DATA_W-1:0]         rs_val,
    output sh_kind_e                  kind,
    output logic [$clog2(DATA_W)-1:0] amt
);
    localparam int SH_W = $clog2(DATA_W);

    logic [IMM_W-1:0] imm_amt;
    logic [REG_W-1:0] reg_amt;

    assign imm_amt = instr[IMM_LSB +: IMM_W];
    assign reg_amt = rs_val[REG_W-1:0];

    // Classify the selected distance and pass the low bits to the shifter.
    always_comb begin
        kind = SH_ARITH;
        amt  = '0;
        if (mode_reg) begin
            if (reg_amt == '0) begin
                kind = SH_PASS;
            end else if (reg_amt < REG_W'(DATA_W)) begin
                kind = SH_ARITH;
                amt  = reg_amt[SH_W-1:0];
            end else begin
                kind = SH_FILL;
            end
        end else begin
            if (imm_amt == '0) begin
                kind = SH_FILL;
            end else begin
                kind = SH_ARITH;
                amt  = SH_W'(imm_amt);
            end
        end
    end

    // R1: the immediate form never yields an unshifted pass-through.
    always_comb begin
        if (!mode_reg) begin
            a_imm_never_pass_r1: assert (kind != SH_PASS)
                else $error("immediate mode decoded as pass");
        end
    end

endmodule

// File: rtl/asr_barrel.sv
// Module: asr_barrel
// Logarithmic arithmetic-right shifter with carry-out, plus the pass and
// sign-fill cases chosen by the decoder.
// Assumes: amt is only meaningful for SH_ARITH and is then non-zero.
module asr_barrel
    import asr_opu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  sh_kind_e                  kind,
    input  logic [$clog2(DATA_W)-1:0] amt,
    input  logic [DATA_W-1:0]         rm,
    input  logic                      c_in,
    output logic [DATA_W-1:0]         res,
    output logic                      cout
);
    localparam int SH_W = $clog2(DATA_W);

    logic                  sign;
    logic [DATA_W-1:0]     stg [0:SH_W];
    logic [SH_W-1:0]       amt_m1;

    assign sign   = rm[DATA_W-1];
    assign stg[0] = rm;
    assign amt_m1 = amt - 1'b1;

    // One stage per distance bit; each stage shifts by a power of two.
    for (genvar i = 0; i < SH_W; i++) begin : g_stage
        localparam int STEP = 1 << i;
        assign stg[i+1] = amt[i] ? {{STEP{sign}}, stg[i][DATA_W-1:STEP]}
                                 : stg[i];
    end

    // Select the result and the carry by class.
    always_comb begin
        case (kind)
            SH_PASS: begin
                res  = rm;
                cout = c_in;
            end
            SH_ARITH: begin
                res  = stg[SH_W];
                cout = rm[amt_m1];
            end
            default: begin
                res  = {DATA_W{sign}};
                cout = sign;
            end
        endcase
    end

    // R3: an arithmetic shift keeps the sign in the top bit.
    always_comb begin
        if (kind == SH_ARITH) begin
            a_shift_keeps_sign_r3: assert (stg[SH_W][DATA_W-1] == rm[DATA_W-1])
                else $error("shift lost the sign bit");
        end
    end

endmodule

// File: rtl/asr_out_reg.sv
// Module: asr_out_reg
// Result register: loads on a strobe, holds otherwise, and raises a
// one-cycle valid. Synchronous active-low reset.
module asr_out_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] d_op,
    input  logic              d_c,
    output logic [DATA_W-1:0] q_op,
    output logic              q_c,
    output logic              q_vld
);

    // Capture the result on load and keep it until the next load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_op <= '0;
            q_c  <= 1'b0;
        end else if (load) begin
            q_op <= d_op;
            q_c  <= d_c;
        end
    end

    // Valid follows the strobe by exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) q_vld <= 1'b0;
        else        q_vld <= load;
    end

    p_hold_without_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(q_op) && $stable(q_c)));

endmodule

// File: rtl/asr_operand_unit.sv
// Module: asr_operand_unit (top)
// Arithmetic-right shifter operand with carry-out, immediate or register
// distance, registered one cycle after in_valid.
// Assumes: the caller has already read rm_val and rs_val from the register file.
module asr_operand_unit
    import asr_opu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int IMM_LSB = 7,
    parameter int IMM_W   = 5,
    parameter int REG_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              mode_reg,
    input  logic              c_in,
    input  logic [DATA_W-1:0] rm_val,
    input  logic [DATA_W-1:0] rs_val,
    input  logic [DATA_W-1:0] instr,
    output logic              out_valid,
    output logic [DATA_W-1:0] operand,
    output logic              carry_out
);
    localparam int SH_W = $clog2(DATA_W);

    sh_kind_e          kind;
    logic [SH_W-1:0]   amt;
    logic [DATA_W-1:0] res;
    logic              cout;

    asr_amount_decode #(
        .DATA_W (DATA_W),
        .IMM_LSB(IMM_LSB),
        .IMM_W  (IMM_W),
        .REG_W  (REG_W)
    ) u_dec (
        .mode_reg(mode_reg),
        .instr   (instr),
        .rs_val  (rs_val),
        .kind    (kind),
        .amt     (amt)
    );

    asr_barrel #(.DATA_W(DATA_W)) u_sh (
        .kind(kind),
        .amt (amt),
        .rm  (rm_val),
        .c_in(c_in),
        .res (res),
        .cout(cout)
    );

    asr_out_reg #(.DATA_W(DATA_W)) u_oreg (
        .clk  (clk),
        .rst_n(rst_n),
        .load (in_valid),
        .d_op (res),
        .d_c  (cout),
        .q_op (operand),
        .q_c  (carry_out),
        .q_vld(out_valid)
    );

    p_valid_after_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_sign_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (operand[DATA_W-1] == $past(rm_val[DATA_W-1])));

    p_reg_zero_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_reg && rs_val[REG_W-1:0] == '0)
        |=> (operand == $past(rm_val) && carry_out == $past(c_in)));

    p_reg_big_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_reg && rs_val[REG_W-1:0] >= REG_W'(DATA_W))
        |=> (operand == {DATA_W{carry_out}}));

    p_imm_zero_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mode_reg && instr[IMM_LSB +: IMM_W] == '0)
        |=> (operand == {DATA_W{carry_out}}));

endmodule

// File: tb/asr_operand_unit_tb_top.sv
`timescale 1ns/1ps
// Directed bench for asr_operand_unit: one task per scenario.
module asr_operand_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        mode_reg = 1'b0;
    logic        c_in = 1'b0;
    logic [31:0] rm_val = '0;
    logic [31:0] rs_val = '0;
    logic [31:0] instr = '0;
    logic        out_valid;
    logic [31:0] operand;
    logic        carry_out;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    asr_operand_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode_reg(mode_reg),
        .c_in(c_in), .rm_val(rm_val), .rs_val(rs_val), .instr(instr),
        .out_valid(out_valid), .operand(operand), .carry_out(carry_out)
    );

    // Reference model built from the requirements: returns {carry, operand}.
    function automatic logic [32:0] ref_model(input logic m, input logic [31:0] rm,
                                              input logic [31:0] rs, input logic [31:0] ins,
                                              input logic c);
        int d;
        logic [31:0] r;
        if (m) d = int'(rs[7:0]);
        else   d = (ins[11:7] == 5'd0) ? 32 : int'(ins[11:7]);
        if (m && d == 0) return {c, rm};
        if (d >= 32) return {rm[31], {32{rm[31]}}};
        r = rm;
        for (int k = 0; k < d; k++) r = {rm[31], r[31:1]};
        return {rm[d-1], r};
    endfunction

    task automatic check(input string req, input logic [32:0] act, input logic [32:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present one strobe, then check the result the cycle after.
    task automatic run_op(input string req, input logic m, input logic [31:0] rm,
                          input logic [31:0] rs, input logic [31:0] ins, input logic c);
        @(negedge clk);
        mode_reg = m; rm_val = rm; rs_val = rs; instr = ins; c_in = c;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid"}, {32'd0, out_valid}, 33'd1);
        check(req, {carry_out, operand}, ref_model(m, rm, rs, ins, c));
    endtask

    task automatic t_reset();
        rst_n = 1'b0; in_valid = 1'b1; rm_val = 32'hFFFF_FFFF; c_in = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 reset valid", {32'd0, out_valid}, 33'd0);
        check("R9 reset data", {carry_out, operand}, 33'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic t_imm_sweep();
        for (int d = 0; d < 32; d++) begin
            for (int s = 0; s < 2; s++) begin
                logic [31:0] rm;
                logic [31:0] ins;
                rm = $urandom();
                rm[31] = s[0];
                ins = 32'(d) << 7;
                run_op(d == 0 ? "R2 imm zero" : "R3 imm shift", 1'b0, rm, $urandom(), ins, s[0]);
            end
        end
    endtask

    task automatic t_imm_junk();
        for (int k = 0; k < 40; k++) begin
            logic [31:0] ins;
            ins = $urandom();
            if (k < 4) ins[11:7] = 5'd0;
            run_op("R1 imm other bits", 1'b0, $urandom(), $urandom(), ins, k[0]);
        end
    endtask

    task automatic t_reg_sweep();
        for (int d = 0; d < 256; d++) begin
            for (int s = 0; s < 2; s++) begin
                logic [31:0] rm;
                rm = $urandom();
                rm[31] = s[0];
                if (d == 0)      run_op("R5 reg zero", 1'b1, rm, 32'(d), $urandom(), s[0]);
                else if (d < 32) run_op("R6 reg shift", 1'b1, rm, 32'(d), $urandom(), ~s[0]);
                else             run_op("R7 reg fill", 1'b1, rm, 32'(d), $urandom(), ~s[0]);
            end
        end
        run_op("R5 reg zero carry", 1'b1, 32'h8000_0001, 32'd0, 32'd0, 1'b0);
    endtask

    task automatic t_reg_upper_ignored();
        int edges[6] = '{0, 1, 31, 32, 33, 255};
        foreach (edges[i]) begin
            for (int k = 0; k < 4; k++) begin
                logic [31:0] rs;
                rs = $urandom();
                if (rs[31:8] == 24'd0) rs[8] = 1'b1;
                rs[7:0] = 8'(edges[i]);
                run_op("R4 rs upper bits", 1'b1, $urandom(), rs, $urandom(), k[0]);
            end
        end
    endtask

    task automatic t_valid_hold();
        logic [32:0] held;
        logic [32:0] e2;
        run_op("R8 first", 1'b1, 32'h8765_4321, 32'd4, 32'd0, 1'b0);
        held = {carry_out, operand};
        rm_val = 32'h1234_5678; rs_val = 32'd1; c_in = 1'b1;
        @(negedge clk);
        check("R8 valid drops", {32'd0, out_valid}, 33'd0);
        check("R8 hold", {carry_out, operand}, held);
        @(negedge clk);
        check("R8 still held", {carry_out, operand}, held);
        // back-to-back strobes
        mode_reg = 1'b0; rm_val = 32'hF000_000F; instr = 32'd3 << 7; in_valid = 1'b1;
        @(negedge clk);
        check("R8 b2b first valid", {32'd0, out_valid}, 33'd1);
        check("R8 b2b first data", {carry_out, operand}, ref_model(1'b0, 32'hF000_000F, 0, 32'd3 << 7, 1'b0));
        rm_val = 32'h0F00_00F0; instr = 32'd5 << 7;
        @(negedge clk);
        in_valid = 1'b0;
        e2 = ref_model(1'b0, 32'h0F00_00F0, 0, 32'd5 << 7, 1'b0);
        check("R8 b2b second valid", {32'd0, out_valid}, 33'd1);
        check("R8 b2b second data", {carry_out, operand}, e2);
        @(negedge clk);
        check("R8 b2b end", {32'd0, out_valid}, 33'd0);
    endtask

    task automatic t_mid_reset();
        run_op("R9 pre", 1'b1, 32'hFFFF_FFF0, 32'd40, 32'd0, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 mid reset data", {carry_out, operand}, 33'd0);
        check("R9 mid reset valid", {32'd0, out_valid}, 33'd0);
        rst_n = 1'b1;
    endtask

    initial begin
        t_reset();
        t_imm_sweep();
        t_imm_junk();
        t_reg_sweep();
        t_reg_upper_ignored();
        t_valid_hold();
        t_mid_reset();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL R8 watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule